// File: doc/BRIEF.md
# Programmable Interval Timer Counter

This block is one timer counter that sits on a plain 32-bit register bus. A count tick comes from the core clock or from an external pin, and a power-of-two prescaler can slow it down. Each tick moves the counter up or down. The counter either wraps at a programmable limit (interval mode) or runs freely to its width and overflows. Three compare registers watch the count. A hit on the first one can toggle a waveform pin whose polarity software selects. Interval, compare and overflow events gather in a sticky status register that clears when it is read. An enable mask then reduces the status to a single interrupt line.

Counting is controlled by a two-state machine. `ST_OFF` holds the count. `ST_RUN` advances it on each tick. The *start* transition (`ST_OFF` to `ST_RUN`) is taken when the control register is written with its halt bit clear. The *halt* transition (`ST_RUN` to `ST_OFF`) is taken when it is written with the halt bit set. A tick in the same cycle as the halting write still counts. Software sets a one-shot reload bit to restart the count.

Top module: `ivt_timer`

## Requirements
- R1: After reset, the counter control register (byte address 0x0C) reads 0x21. The count (0x18) and the status register (0x54) read 0, and `wave_o` and `irq_o` are low. While control bit 0 (halt) is set, the count does not change, whatever the tick source does.
- R2: Registers are decoded by byte address: clock control 0x00, counter control 0x0C, count 0x18 (read-only), interval 0x24, compare 0/1/2 at 0x30/0x3C/0x48, status 0x54, enable 0x60. Interval, compare and count values are truncated to `CNT_W` bits. Any other address reads 0.
- R3: When counting up (control bit 2 clear), a tick at a count equal to the interval, with interval mode set (control bit 1), restarts the count at 0 and sets status bit 0. In free-running mode, a tick at all-ones restarts the count at 0 and sets status bit 4.
- R4: When counting down (control bit 2 set), a tick at count 0 loads the interval and sets status bit 0 in interval mode. In free-running mode it loads all-ones and sets status bit 4.
- R5: A control write with bit 4 set loads the count on that write's clock edge: 0 when the written bit 2 is clear, the interval when it is set. The same write restarts the prescaler and clears the waveform toggle. Bit 4 always reads back 0.
- R6: The clock control register holds prescale enable (bit 0) and prescale exponent N (bits 4:1). With prescale enabled, the counter advances once per 2^(N+1) source ticks. Without it, the counter advances on every source tick.
- R7: When clock control bit 5 is clear, every core clock is a source tick. When it is set, `ext_clk_i` is synchronized through two flops, and each rising edge (bit 6 clear) or each falling edge (bit 6 set) gives one source tick.
- R8: With compare mode on (control bit 3), a tick taken while the count equals compare register i sets status bit 1+i. With compare mode off, compare registers set no status.
- R9: Control bit 5 is an active-low waveform enable and bit 6 selects inverted polarity. While the waveform is enabled, each compare-0 event toggles an internal level, and `wave_o` shows that level, inverted when bit 6 is set. While the waveform is disabled, `wave_o` is 0.
- R10: Status bits are sticky. A read of 0x54 returns them and clears them at the read's clock edge. An event in that same cycle stays set for the next read.
- R11: `irq_o` is high exactly when a status bit and the matching bit of the enable register (0x60, low 5 bits) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_re | input | 1 | Read strobe; needed for clear-on-read of status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_clk_i | input | 1 | External count source pin, asynchronous |
| wave_o | output | 1 | Compare-driven waveform output |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can land in the same clock edge. The first pair is an event that sets a status bit and a status read that clears it. This is provoked with an interval of 0, so every tick raises an interval event while the status is read back to back. Each read must return the bit, and only the read after the counter stops may return 0. The second pair is a tick and a halting control write in the same cycle. Every vector run ends on such a write, and the expected counts include that final tick.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 32;
    localparam int NUM_MATCH    = 3;
    localparam int NUM_IRQ      = 5;
    localparam int MATCH_STRIDE = 12;

    localparam logic [ADDR_W-1:0] A_CLK    = 8'h00;
    localparam logic [ADDR_W-1:0] A_CTL    = 8'h0C;
    localparam logic [ADDR_W-1:0] A_CNT    = 8'h18;
    localparam logic [ADDR_W-1:0] A_IVAL   = 8'h24;
    localparam logic [ADDR_W-1:0] A_MATCH0 = 8'h30;
    localparam logic [ADDR_W-1:0] A_ISR    = 8'h54;
    localparam logic [ADDR_W-1:0] A_IER    = 8'h60;

    // status bit positions: interval, compare 0..2, overflow
    localparam int IRQ_INT = 0;
    localparam int IRQ_M0  = 1;
    localparam int IRQ_OVF = 4;

    // clock control, bit 6 down to bit 0
    typedef struct packed {
        logic       edge_fall;
        logic       src_ext;
        logic [3:0] psc_n;
        logic       psc_en;
    } clk_cfg_t;

    // counter control, bit 6 down to bit 0
    typedef struct packed {
        logic wpol;
        logic wave_off;
        logic reload;
        logic match_on;
        logic down;
        logic intv;
        logic halt;
    } cnt_cfg_t;

    localparam logic [6:0] CTL_RESET = 7'h21;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_st_t;

endpackage

// File: rtl/ivt_tick_gen.sv
module ivt_tick_gen
    import ivt_pkg::*;
#(
    parameter int PSC_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ext_i,
    input  clk_cfg_t cfg,
    input  logic     active,
    input  logic     restart,
    output logic     tick_o
);

    localparam int SH_W = $clog2(PSC_W + 1) + 1;

    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              rise, fall, src_tick;
    logic [PSC_W-1:0]  psc_q;
    logic [PSC_W-1:0]  psc_lim;
    logic [SH_W-1:0]   shamt;

    // two-flop synchronizer plus one flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], ext_i};
            prev_q <= sync_q[SYNC_N-1];
        end
    end

    assign rise = sync_q[SYNC_N-1] & ~prev_q;
    assign fall = ~sync_q[SYNC_N-1] & prev_q;

    always_comb begin
        if (cfg.src_ext) src_tick = cfg.edge_fall ? fall : rise;
        else             src_tick = 1'b1;
    end

    // limit is 2^(N+1)-1; wraps correctly to all-ones when N+1 equals PSC_W
    assign shamt   = SH_W'(cfg.psc_n) + SH_W'(1);
    assign psc_lim = (PSC_W'(1) << shamt) - PSC_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (restart || !active || !cfg.psc_en) begin
            psc_q <= '0;
        end else if (src_tick) begin
            psc_q <= (psc_q == psc_lim) ? '0 : psc_q + PSC_W'(1);
        end
    end

    assign tick_o = src_tick & (!cfg.psc_en | (psc_q == psc_lim));

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
    import ivt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic          ctl_halt,
    input  logic          reload,
    input  logic          reload_down,
    input  logic          tick,
    input  logic          intv,
    input  logic          down,
    input  logic [CW-1:0] ival,
    output logic [CW-1:0] cnt_o,
    output logic          run_o,
    output logic          adv_o,
    output logic          evt_int_o,
    output logic          evt_ovf_o
);

    localparam logic [CW-1:0] ALL1 = '1;

    run_st_t       st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        evt_int_o = 1'b0;
        evt_ovf_o = 1'b0;
        adv_o     = 1'b0;
        unique case (st_q)
            ST_OFF: if (ctl_wr && !ctl_halt) st_d = ST_RUN;   // start
            ST_RUN: if (ctl_wr &&  ctl_halt) st_d = ST_OFF;   // halt
            default: st_d = ST_OFF;
        endcase
        if (reload) begin
            cnt_d = reload_down ? ival : '0;
        end else if (st_q == ST_RUN && tick) begin
            adv_o = 1'b1;
            if (!down) begin
                if (intv && cnt_q == ival) begin
                    cnt_d     = '0;
                    evt_int_o = 1'b1;
                end else if (cnt_q == ALL1) begin
                    cnt_d     = '0;
                    evt_ovf_o = 1'b1;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end else begin
                if (cnt_q == '0) begin
                    if (intv) begin
                        cnt_d     = ival;
                        evt_int_o = 1'b1;
                    end else begin
                        cnt_d     = ALL1;
                        evt_ovf_o = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
        end
    end

    assign cnt_o = cnt_q;
    assign run_o = (st_q == ST_RUN);

endmodule

// File: rtl/ivt_match.sv
module ivt_match #(
    parameter int CW = 16,
    parameter int NM = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          match_on,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] match_val [NM],
    input  logic          wave_off,
    input  logic          wave_pol,
    input  logic          reload,
    output logic [NM-1:0] evt_o,
    output logic          wave_t_o,
    output logic          wave_o
);

    logic wave_q;

    for (genvar g = 0; g < NM; g++) begin : g_cmp
        assign evt_o[g] = adv & match_on & (cnt == match_val[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    wave_q <= 1'b0;
        else if (reload)               wave_q <= 1'b0;
        else if (evt_o[0] && !wave_off) wave_q <= ~wave_q;
    end

    assign wave_t_o = wave_q;
    assign wave_o   = !wave_off & (wave_q ^ wave_pol);

endmodule

// File: rtl/ivt_irq.sv
module ivt_irq #(
    parameter int NI = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NI-1:0] evt,
    input  logic          clr,
    input  logic          ier_wr,
    input  logic [NI-1:0] ier_wdata,
    output logic [NI-1:0] isr_o,
    output logic [NI-1:0] ier_o,
    output logic          irq_o
);

    logic [NI-1:0] isr_q, ier_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q <= '0;
            ier_q <= '0;
        end else begin
            isr_q <= (clr ? '0 : isr_q) | evt;
            if (ier_wr) ier_q <= ier_wdata;
        end
    end

    assign isr_o = isr_q;
    assign ier_o = ier_q;
    assign irq_o = |(isr_q & ier_q);

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ext_clk_i,
    output logic        wave_o,
    output logic        irq_o
);

    clk_cfg_t             clk_cfg_q;
    cnt_cfg_t             cnt_cfg_q, ctl_new, ctl_store;
    logic [CNT_W-1:0]     ival_q;
    logic [CNT_W-1:0]     match_q [NUM_MATCH];
    logic                 wr_clk, wr_ctl, wr_ival, wr_ier;
    logic [NUM_MATCH-1:0] wr_m;
    logic                 reload_w, tick_w, run_w, adv_w;
    logic                 evt_int_w, evt_ovf_w, isr_clr_w, wave_t_w;
    logic [CNT_W-1:0]     cnt_w;
    logic [NUM_MATCH-1:0] evt_m_w;
    logic [NUM_IRQ-1:0]   evt_w, isr_w, ier_w;

    assign wr_clk    = bus_we && bus_addr == A_CLK;
    assign wr_ctl    = bus_we && bus_addr == A_CTL;
    assign wr_ival   = bus_we && bus_addr == A_IVAL;
    assign wr_ier    = bus_we && bus_addr == A_IER;
    assign isr_clr_w = bus_re && bus_addr == A_ISR;

    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_mdec
        assign wr_m[g] = bus_we && bus_addr == ADDR_W'(A_MATCH0 + g * MATCH_STRIDE);
    end

    if (CNT_W < DATA_W) begin : g_unused
        logic unused_hi;
        assign unused_hi = ^bus_wdata[DATA_W-1:CNT_W];
    end

    always_comb begin
        ctl_new          = cnt_cfg_t'(bus_wdata[6:0]);
        ctl_store        = ctl_new;
        ctl_store.reload = 1'b0;
    end
    assign reload_w = wr_ctl && ctl_new.reload;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_cfg_q <= '0;
            cnt_cfg_q <= cnt_cfg_t'(CTL_RESET);
            ival_q    <= '0;
            for (int i = 0; i < NUM_MATCH; i++) match_q[i] <= '0;
        end else begin
            if (wr_clk)  clk_cfg_q <= clk_cfg_t'(bus_wdata[6:0]);
            if (wr_ctl)  cnt_cfg_q <= ctl_store;
            if (wr_ival) ival_q    <= bus_wdata[CNT_W-1:0];
            for (int i = 0; i < NUM_MATCH; i++) begin
                if (wr_m[i]) match_q[i] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CLK)  bus_rdata[6:0]       = clk_cfg_q;
        if (bus_addr == A_CTL)  bus_rdata[6:0]       = cnt_cfg_q;
        if (bus_addr == A_CNT)  bus_rdata[CNT_W-1:0] = cnt_w;
        if (bus_addr == A_IVAL) bus_rdata[CNT_W-1:0] = ival_q;
        if (bus_addr == A_ISR)  bus_rdata[NUM_IRQ-1:0] = isr_w;
        if (bus_addr == A_IER)  bus_rdata[NUM_IRQ-1:0] = ier_w;
        for (int i = 0; i < NUM_MATCH; i++) begin
            if (bus_addr == ADDR_W'(A_MATCH0 + i * MATCH_STRIDE))
                bus_rdata[CNT_W-1:0] = match_q[i];
        end
    end

    ivt_tick_gen #(.PSC_W(16), .SYNC_N(2)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_i   (ext_clk_i),
        .cfg     (clk_cfg_q),
        .active  (run_w),
        .restart (reload_w),
        .tick_o  (tick_w)
    );

    ivt_counter #(.CW(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (wr_ctl),
        .ctl_halt    (ctl_new.halt),
        .reload      (reload_w),
        .reload_down (ctl_new.down),
        .tick        (tick_w),
        .intv        (cnt_cfg_q.intv),
        .down        (cnt_cfg_q.down),
        .ival        (ival_q),
        .cnt_o       (cnt_w),
        .run_o       (run_w),
        .adv_o       (adv_w),
        .evt_int_o   (evt_int_w),
        .evt_ovf_o   (evt_ovf_w)
    );

    ivt_match #(.CW(CNT_W), .NM(NUM_MATCH)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv_w),
        .match_on  (cnt_cfg_q.match_on),
        .cnt       (cnt_w),
        .match_val (match_q),
        .wave_off  (cnt_cfg_q.wave_off),
        .wave_pol  (cnt_cfg_q.wpol),
        .reload    (reload_w),
        .evt_o     (evt_m_w),
        .wave_t_o  (wave_t_w),
        .wave_o    (wave_o)
    );

    assign evt_w = {evt_ovf_w, evt_m_w, evt_int_w};

    ivt_irq #(.NI(NUM_IRQ)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt_w),
        .clr       (isr_clr_w),
        .ier_wr    (wr_ier),
        .ier_wdata (bus_wdata[NUM_IRQ-1:0]),
        .isr_o     (isr_w),
        .ier_o     (ier_w),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
    parameter int CW = 16,
    parameter int NI = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          reload,
    input logic [CW-1:0] count,
    input logic [CW-1:0] ival,
    input logic          down,
    input logic          evt_int,
    input logic          tick,
    input logic          psc_en,
    input logic [NI-1:0] isr,
    input logic          isr_clr,
    input logic          m0_evt,
    input logic          wave_t
);

    // R1
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload) |=> $stable(count));

    // R3
    wrap_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_int && !reload) |=> (count == ($past(down) ? $past(ival) : '0)));

    // R6
    psc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psc_en) |=> !(tick && psc_en));

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !isr_clr |=> ((isr & $past(isr)) == $past(isr)));

    // R9
    wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!m0_evt && !reload) |=> $stable(wave_t));

endmodule

bind ivt_timer ivt_timer_chk #(.CW(CNT_W), .NI(5)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .reload  (reload_w),
    .count   (cnt_w),
    .ival    (ival_q),
    .down    (cnt_cfg_q.down),
    .evt_int (evt_int_w),
    .tick    (tick_w),
    .psc_en  (clk_cfg_q.psc_en),
    .isr     (isr_w),
    .isr_clr (isr_clr_w),
    .m0_evt  (evt_m_w[0]),
    .wave_t  (wave_t_w)
);

// File: tb/test_ivt_timer.sv
module test_ivt_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ext = 1'b0;
    logic        wave;
    logic        irq;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    ivt_timer #(.CNT_W(16)) i_ivt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_re    (re),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .ext_clk_i (ext),
        .wave_o    (wave),
        .irq_o     (irq)
    );

    typedef struct packed {
        logic [7:0]  clkc;
        logic [7:0]  cntc;
        logic [15:0] ival;
        logic [15:0] m0;
        logic [15:0] m1;
        logic [15:0] m2;
        logic [15:0] ticks;
        logic [15:0] ecnt;
        logic [7:0]  eisr;
    } vec_t;

    // clock ctrl, counter ctrl (halt and reload added by the loop), interval,
    // compares, clock edges run, expected count, expected status
    localparam vec_t VECS [8] = '{
        '{8'h00, 8'h20, 16'd0, 16'd5,    16'd5,    16'd5,    16'd10, 16'd10,   8'h00},
        '{8'h00, 8'h22, 16'd4, 16'hFFF0, 16'hFFF0, 16'hFFF0, 16'd12, 16'd2,    8'h01},
        '{8'h00, 8'h26, 16'd4, 16'hFFF0, 16'hFFF0, 16'hFFF0, 16'd7,  16'd2,    8'h01},
        '{8'h00, 8'h24, 16'd3, 16'hFFF0, 16'hFFF0, 16'hFFF0, 16'd5,  16'hFFFE, 8'h10},
        '{8'h00, 8'h2A, 16'd9, 16'd3,    16'd5,    16'd8,    16'd6,  16'd6,    8'h06},
        '{8'h00, 8'h2E, 16'd9, 16'd1,    16'd20,   16'd8,    16'd3,  16'd6,    8'h08},
        '{8'h03, 8'h20, 16'd0, 16'hFFF0, 16'hFFF0, 16'hFFF0, 16'd10, 16'd2,    8'h00},
        '{8'h01, 8'h26, 16'd2, 16'hFFF0, 16'hFFF0, 16'hFFF0, 16'd8,  16'd1,    8'h01}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; re = 1'b1;
        #2;
        d = rdata;
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic ext_pattern();
        // three rising and two falling edges on the pin
        ext = 1'b1; repeat (4) @(negedge clk);
        ext = 1'b0; repeat (4) @(negedge clk);
        ext = 1'b1; repeat (4) @(negedge clk);
        ext = 1'b0; repeat (4) @(negedge clk);
        ext = 1'b1; repeat (6) @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h0C, d); chk("R1 ctrl reset", d, 32'h21);
        rd(8'h18, d); chk("R1 count reset", d, 32'h0);
        rd(8'h54, d); chk("R1 status reset", d, 32'h0);
        chk("R1 wave reset", {31'd0, wave}, 32'h0);
        chk("R1 irq reset", {31'd0, irq}, 32'h0);

        // vector table: R3 R4 R6 R8 R10
        for (int v = 0; v < 8; v++) begin
            wr(8'h24, 32'(VECS[v].ival));
            wr(8'h30, 32'(VECS[v].m0));
            wr(8'h3C, 32'(VECS[v].m1));
            wr(8'h48, 32'(VECS[v].m2));
            wr(8'h00, 32'(VECS[v].clkc));
            wr(8'h0C, 32'(VECS[v].cntc | 8'h10));
            repeat (int'(VECS[v].ticks) - 1) @(negedge clk);
            wr(8'h0C, 32'(VECS[v].cntc | 8'h01));
            rd(8'h18, d); chk($sformatf("R3 R4 R6 vector %0d count", v), d, 32'(VECS[v].ecnt));
            rd(8'h54, d); chk($sformatf("R8 vector %0d status", v), d, 32'(VECS[v].eisr));
            rd(8'h54, d); chk($sformatf("R10 vector %0d cleared", v), d, 32'h0);
        end

        // R2 width truncation and unmapped address
        wr(8'h24, 32'h0001_2345);
        rd(8'h24, d); chk("R2 interval truncated", d, 32'h2345);
        rd(8'h04, d); chk("R2 unmapped reads 0", d, 32'h0);
        wr(8'h3C, 32'hABCD_0042);
        rd(8'h3C, d); chk("R2 compare 1 at 0x3C", d, 32'h0042);

        // R5 reload to interval when counting down; bit 4 reads 0
        wr(8'h0C, 32'h37);
        rd(8'h0C, d); chk("R5 reload bit reads 0", d, 32'h27);
        rd(8'h18, d); chk("R5 down reload loads interval", d, 32'h2345);
        wr(8'h0C, 32'h31);
        rd(8'h18, d); chk("R5 up reload loads 0", d, 32'h0);

        // R9 waveform
        wr(8'h00, 32'h00);
        wr(8'h24, 32'd9);
        wr(8'h30, 32'd2);
        wr(8'h0C, 32'h1A);
        repeat (3) @(negedge clk);
        wr(8'h0C, 32'h0B);
        chk("R9 wave toggled on compare 0", {31'd0, wave}, 32'h1);
        wr(8'h0C, 32'h4B);
        chk("R9 wave inverted polarity", {31'd0, wave}, 32'h0);
        wr(8'h0C, 32'h2B);
        chk("R9 wave disabled is 0", {31'd0, wave}, 32'h0);
        wr(8'h0C, 32'h0B);
        chk("R9 wave enabled again", {31'd0, wave}, 32'h1);
        rd(8'h54, d); chk("R8 compare 0 status", d, 32'h02);

        // R11 interrupt mask
        wr(8'h60, 32'h01);
        wr(8'h24, 32'd1);
        wr(8'h0C, 32'h32);
        @(negedge clk);
        wr(8'h0C, 32'h23);
        chk("R11 irq with enabled interval", {31'd0, irq}, 32'h1);
        wr(8'h60, 32'h02);
        chk("R11 irq masked", {31'd0, irq}, 32'h0);
        wr(8'h60, 32'h01);
        rd(8'h54, d); chk("R3 interval status", d, 32'h01);
        chk("R11 irq after clear", {31'd0, irq}, 32'h0);
        wr(8'h60, 32'h00);

        // R10 event in the same cycle as a status read
        wr(8'h24, 32'd0);
        wr(8'h0C, 32'h32);
        repeat (2) @(negedge clk);
        rd(8'h54, d); chk("R10 first read", d, 32'h01);
        rd(8'h54, d); chk("R10 event kept over clear", d, 32'h01);
        wr(8'h0C, 32'h23);
        rd(8'h54, d); chk("R10 halting tick event", d, 32'h01);
        rd(8'h54, d); chk("R10 cleared once stopped", d, 32'h00);
        chk("R11 irq off with mask 0", {31'd0, irq}, 32'h0);

        // R7 external rising edges
        wr(8'h00, 32'h20);
        wr(8'h0C, 32'h30);
        ext_pattern();
        wr(8'h0C, 32'h21);
        rd(8'h18, d); chk("R7 rising edges counted", d, 32'd3);

        // R1 halted counter ignores the pin
        ext = 1'b0; repeat (5) @(negedge clk);
        ext = 1'b1; repeat (5) @(negedge clk);
        rd(8'h18, d); chk("R1 halted count holds", d, 32'd3);

        // R7 external falling edges
        ext = 1'b0; repeat (6) @(negedge clk);
        wr(8'h00, 32'h60);
        wr(8'h0C, 32'h30);
        ext_pattern();
        wr(8'h0C, 32'h21);
        rd(8'h18, d); chk("R7 falling edges counted", d, 32'd2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule